// File: doc/BRIEF.md
# Dual-Stack Domain Execution Unit

This block is the execution core of one typed data domain in a stack-first processor. It holds two last-in-first-out operand stacks. The main stack carries the full operation set. The staging stack carries only cheap preparation work. The block also has a read-only bank of literal constants and a writable bank of pinned registers. Both banks feed a stack top and take no immediate field.

One decoded command arrives per cycle on a valid/ready port. A command carries an opcode, a form bit, a stack select and a register index. The form bit picks the consuming form, which pops the operands, or the preserving form, which only peeks at them and pushes the result on top. A command that would read more entries than a stack holds is rejected. So is a command that would grow a stack past capacity, or one that names an operation the staging stack lacks. A rejected command leaves every stack and register unchanged and sets a sticky fault flag, which stays set until reset. Memory transfers appear only as a push-data input handshake (load) and a pop-data output handshake (store).

Top module: `dual_stack_exec`

## Requirements
- R1: After reset both stack depths read 0, both top outputs read 0, all three fault flags are 0, every pinned register reads 0 and cmd_ready is 1 for any command other than load or store.
- R2: The consuming binary opcodes ADD=0, SUB=1, AND=2, OR=3 and XOR=4 act on the main stack. Each pops two entries and pushes one result, so depth falls by one. SUB yields second-from-top minus top.
- R3: The comparisons LT=5 (unsigned, second-from-top < top) and EQ=6 push 1 for true and 0 for false.
- R4: With the form bit cmd_keep=1, a binary or unary opcode leaves its operands in place and pushes its result above them.
- R5: The unary opcodes INC=8, DEC=9 and NOT=10 (bitwise invert) work on either stack. The consuming form replaces the top entry.
- R6: The staging stack (cmd_stg=1) rejects opcodes 0 to 7. It raises flt_illegal and leaves both stacks unchanged.
- R7: LDC=11 pushes constant idx onto the selected stack. The constants for index 0 to 7 are 0, 1, 0xFFFFFFFF, 2, 4, 8, 0xFF and 0xFFFFFFFF.
- R8: STP=13 copies the top into pinned register idx. It pops in the consuming form and keeps the entry in the preserving form. LDP=12 pushes pinned register idx.
- R9: XFR=14 moves the top of the selected stack onto the other stack. The consuming form pops the source.
- R10: LOAD=15 pushes push_data onto the selected stack and completes only together with push_valid. STORE=7 (main only) presents the main top on pop_data with pop_valid, completes only with pop_ready, and pops in the consuming form.
- R11: A command that needs more operands than the stack holds sets flt_under and changes no state.
- R12: A command that would push a stack beyond 16 entries sets flt_over and changes no state. Fault flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_keep | input | 1 | 1 = preserving form, 0 = consuming form |
| cmd_stg | input | 1 | 1 = staging stack, 0 = main stack |
| cmd_idx | input | 3 | Constant or pinned register index |
| push_valid | input | 1 | Load data present |
| push_ready | output | 1 | Load data taken |
| push_data | input | 32 | Load data |
| pop_valid | output | 1 | Store data present |
| pop_ready | input | 1 | Store data taken |
| pop_data | output | 32 | Store data |
| main_top | output | 32 | Main stack top, 0 when empty |
| main_depth | output | 5 | Main stack entry count |
| stg_top | output | 32 | Staging stack top, 0 when empty |
| stg_depth | output | 5 | Staging stack entry count |
| flt_over | output | 1 | Sticky overflow fault |
| flt_under | output | 1 | Sticky underflow fault |
| flt_illegal | output | 1 | Sticky staging-illegal fault |

## Verification
The bench walks a vector sequence in which each step depends on the stack left by the one before. A design that swapped the SUB or LT operand order would show a wrong top value, and one that popped in the preserving form would show a wrong depth. Directed tests fill the main stack to exactly 16 and then push once more. They also issue an ADD on an empty stack and an arithmetic op on the staging stack. A design that wrapped its depth counter, corrupted the top, or altered the other stack on a rejected command would show changed outputs. Other directed tests stall the load and store handshakes, which catches a design that commits without its data partner, and check that fault flags stay set through later legal commands.

// File: rtl/dsx_pkg.sv
package dsx_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR  = 4'd3,
        OP_XOR = 4'd4, OP_LT  = 4'd5, OP_EQ  = 4'd6, OP_STORE = 4'd7,
        OP_INC = 4'd8, OP_DEC = 4'd9, OP_NOT = 4'd10, OP_LDC = 4'd11,
        OP_LDP = 4'd12, OP_STP = 4'd13, OP_XFR = 4'd14, OP_LOAD = 4'd15
    } op_e;

    function automatic logic is_binary(input op_e op);
        return op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_LT, OP_EQ};
    endfunction

    function automatic logic is_unary(input op_e op);
        return op inside {OP_INC, OP_DEC, OP_NOT};
    endfunction
endpackage

// File: rtl/dsx_const_rom.sv
module dsx_const_rom #(
    parameter int W  = 32,
    parameter int IW = 3
) (
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  val
);
    always_comb begin
        unique case (idx)
            IW'(0): val = '0;
            IW'(1): val = W'(1);
            IW'(2): val = '1;
            IW'(3): val = W'(2);
            IW'(4): val = W'(4);
            IW'(5): val = W'(8);
            IW'(6): val = W'(8'hFF);
            default: val = '1;
        endcase
    end
endmodule

// File: rtl/dsx_alu.sv
module dsx_alu
    import dsx_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] nos,
    input  logic [W-1:0] tos,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_ADD:  res = nos + tos;
            OP_SUB:  res = nos - tos;
            OP_AND:  res = nos & tos;
            OP_OR:   res = nos | tos;
            OP_XOR:  res = nos ^ tos;
            OP_LT:   res = W'(nos < tos);
            OP_EQ:   res = W'(nos == tos);
            OP_INC:  res = tos + W'(1);
            OP_DEC:  res = tos - W'(1);
            OP_NOT:  res = ~tos;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/dsx_lifo.sv
module dsx_lifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int DW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [DW-1:0] nxt_depth,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  top,
    output logic [W-1:0]  second,
    output logic [DW-1:0] depth
);
    typedef struct packed {
        logic [DW-1:0]             cnt;
        logic [DEPTH-1:0][W-1:0]   mem;
    } lifo_t;

    lifo_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd) begin
            st_d.cnt = nxt_depth;
            if (wr_en) st_d.mem[AW'(nxt_depth - DW'(1))] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign depth  = st_q.cnt;
    assign top    = (st_q.cnt == '0) ? '0 : st_q.mem[AW'(st_q.cnt - DW'(1))];
    assign second = (st_q.cnt < DW'(2)) ? '0 : st_q.mem[AW'(st_q.cnt - DW'(2))];

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= DW'(DEPTH)); // R12
endmodule

// File: rtl/dual_stack_exec.sv
module dual_stack_exec
    import dsx_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int PIN_N = 8,
    localparam int DW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(PIN_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [3:0]    cmd_op,
    input  logic          cmd_keep,
    input  logic          cmd_stg,
    input  logic [IW-1:0] cmd_idx,
    input  logic          push_valid,
    output logic          push_ready,
    input  logic [W-1:0]  push_data,
    output logic          pop_valid,
    input  logic          pop_ready,
    output logic [W-1:0]  pop_data,
    output logic [W-1:0]  main_top,
    output logic [DW-1:0] main_depth,
    output logic [W-1:0]  stg_top,
    output logic [DW-1:0] stg_depth,
    output logic          flt_over,
    output logic          flt_under,
    output logic          flt_illegal
);
    typedef struct packed {
        logic                    ovf;
        logic                    unf;
        logic                    ill;
        logic [PIN_N-1:0][W-1:0] pin;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    op_e           op;
    logic [W-1:0]  m_sec, s_top_w, s_sec, alu_res, const_val, res;
    logic [W-1:0]  src_top, src_sec;
    logic [DW-1:0] src_dep, oth_dep, src_nd;
    logic [1:0]    need, pops;
    logic          pushes, legal, unf, ovf, ok, fire, commit;
    logic          m_upd, m_wr, s_upd, s_wr;
    logic [DW-1:0] m_nd, s_nd;
    logic [W-1:0]  m_wd, s_wd;

    assign op = op_e'(cmd_op);

    dsx_lifo #(.W(W), .DEPTH(DEPTH)) u_main (
        .clk(clk), .rst_n(rst_n), .upd(m_upd), .nxt_depth(m_nd), .wr_en(m_wr),
        .wr_data(m_wd), .top(main_top), .second(m_sec), .depth(main_depth));

    dsx_lifo #(.W(W), .DEPTH(DEPTH)) u_stg (
        .clk(clk), .rst_n(rst_n), .upd(s_upd), .nxt_depth(s_nd), .wr_en(s_wr),
        .wr_data(s_wd), .top(s_top_w), .second(s_sec), .depth(stg_depth));

    assign stg_top = s_top_w;

    dsx_alu #(.W(W)) u_alu (.op(op), .nos(src_sec), .tos(src_top), .res(alu_res));

    dsx_const_rom #(.W(W), .IW(IW)) u_rom (.idx(cmd_idx), .val(const_val));

    // Decode: operand need, pops, pushes, legality
    always_comb begin
        src_top = cmd_stg ? s_top_w   : main_top;
        src_sec = cmd_stg ? s_sec     : m_sec;
        src_dep = cmd_stg ? stg_depth : main_depth;
        oth_dep = cmd_stg ? main_depth : stg_depth;

        if (is_binary(op))                                   need = 2'd2;
        else if (is_unary(op) || op inside {OP_STP, OP_XFR, OP_STORE}) need = 2'd1;
        else                                                 need = 2'd0;
        pops   = cmd_keep ? 2'd0 : need;
        pushes = is_binary(op) || is_unary(op) || op inside {OP_LDC, OP_LDP, OP_LOAD};
        legal  = !(cmd_stg && (is_binary(op) || op == OP_STORE));
        unf    = src_dep < DW'(need);
        src_nd = src_dep - DW'(pops) + DW'(pushes);
        ovf    = !unf && ((pushes && pops == 2'd0 && src_dep == DW'(DEPTH)) ||
                          (op == OP_XFR && oth_dep == DW'(DEPTH)));
        ok     = legal && !unf && !ovf;

        unique case (op)
            OP_LDC:  res = const_val;
            OP_LDP:  res = ctl_q.pin[cmd_idx];
            OP_LOAD: res = push_data;
            default: res = alu_res;
        endcase

        if (op == OP_LOAD)                cmd_ready = push_valid;
        else if (op == OP_STORE && ok)    cmd_ready = pop_ready;
        else                              cmd_ready = 1'b1;
        fire   = cmd_valid && cmd_ready;
        commit = fire && ok;
    end

    assign push_ready = cmd_valid && (op == OP_LOAD);
    assign pop_valid  = cmd_valid && (op == OP_STORE) && ok;
    assign pop_data   = main_top;

    // Stack update steering
    always_comb begin
        m_upd = 1'b0; m_nd = main_depth; m_wr = 1'b0; m_wd = res;
        s_upd = 1'b0; s_nd = stg_depth;  s_wr = 1'b0; s_wd = res;
        if (commit) begin
            if (cmd_stg) begin
                s_upd = 1'b1; s_nd = src_nd; s_wr = pushes;
            end else begin
                m_upd = 1'b1; m_nd = src_nd; m_wr = pushes;
            end
            if (op == OP_XFR) begin
                if (cmd_stg) begin
                    m_upd = 1'b1; m_nd = main_depth + DW'(1); m_wr = 1'b1; m_wd = src_top;
                end else begin
                    s_upd = 1'b1; s_nd = stg_depth + DW'(1);  s_wr = 1'b1; s_wd = src_top;
                end
            end
        end
    end

    // Pinned registers and sticky faults
    always_comb begin
        ctl_d = ctl_q;
        if (commit && op == OP_STP) ctl_d.pin[cmd_idx] = src_top;
        if (fire && !legal)             ctl_d.ill = 1'b1;
        if (fire && legal && unf)       ctl_d.unf = 1'b1;
        if (fire && legal && ovf)       ctl_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign flt_over    = ctl_q.ovf;
    assign flt_under   = ctl_q.unf;
    assign flt_illegal = ctl_q.ill;

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_over || flt_under || flt_illegal) |=>
        ($past(flt_over) -> flt_over) && ($past(flt_under) -> flt_under) &&
        ($past(flt_illegal) -> flt_illegal)); // R12
    AST_CONSUME_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_stg && !cmd_keep && cmd_op <= 4'd6 &&
         main_depth >= DW'(2)) |=> main_depth == $past(main_depth) - DW'(1)); // R2
    AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_stg && cmd_op <= 4'd6 && main_depth == '0) |=>
        (main_depth == '0 && flt_under)); // R11
    AST_STG_NO_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_stg && cmd_op <= 4'd7) |=>
        ($stable(stg_depth) && $stable(main_depth) && flt_illegal)); // R6
    AST_LOAD_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready) |-> (cmd_valid && cmd_ready)); // R10
    AST_STORE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !pop_ready) |-> !cmd_ready); // R10
endmodule

// File: tb/test_dual_stack_exec.sv
module test_dual_stack_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_keep = 1'b0, cmd_stg = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [2:0]  cmd_idx = 3'd0;
    logic        push_valid = 1'b0, pop_ready = 1'b0;
    logic [31:0] push_data = 32'd0;
    logic        cmd_ready, push_ready, pop_valid;
    logic [31:0] pop_data, main_top, stg_top;
    logic [4:0]  main_depth, stg_depth;
    logic        flt_over, flt_under, flt_illegal;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    dual_stack_exec i_dual_stack_exec (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_keep(cmd_keep), .cmd_stg(cmd_stg), .cmd_idx(cmd_idx),
        .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
        .main_top(main_top), .main_depth(main_depth), .stg_top(stg_top),
        .stg_depth(stg_depth), .flt_over(flt_over), .flt_under(flt_under),
        .flt_illegal(flt_illegal));

    typedef struct packed {
        logic [3:0]  op;
        logic        keep;
        logic        stg;
        logic [2:0]  idx;
        logic [31:0] din;
        logic [31:0] mtop;
        logic [4:0]  mdep;
        logic [31:0] stop;
        logic [4:0]  sdep;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd15, 1'b0, 1'b0, 3'd0, 32'd10,  32'd10,  5'd1, 32'd0, 5'd0, 4'd10},        // R10
        '{4'd15, 1'b0, 1'b0, 3'd0, 32'd3,   32'd3,   5'd2, 32'd0, 5'd0, 4'd10},        // R10
        '{4'd1,  1'b0, 1'b0, 3'd0, 32'd0,   32'd7,   5'd1, 32'd0, 5'd0, 4'd2},         // R2
        '{4'd11, 1'b0, 1'b0, 3'd5, 32'd0,   32'd8,   5'd2, 32'd0, 5'd0, 4'd7},         // R7
        '{4'd0,  1'b1, 1'b0, 3'd0, 32'd0,   32'd15,  5'd3, 32'd0, 5'd0, 4'd4},         // R4
        '{4'd5,  1'b0, 1'b0, 3'd0, 32'd0,   32'd1,   5'd2, 32'd0, 5'd0, 4'd3},         // R3
        '{4'd6,  1'b1, 1'b0, 3'd0, 32'd0,   32'd0,   5'd3, 32'd0, 5'd0, 4'd3},         // R3
        '{4'd8,  1'b1, 1'b0, 3'd0, 32'd0,   32'd1,   5'd4, 32'd0, 5'd0, 4'd5},         // R5
        '{4'd4,  1'b0, 1'b0, 3'd0, 32'd0,   32'd1,   5'd3, 32'd0, 5'd0, 4'd2},         // R2
        '{4'd15, 1'b0, 1'b1, 3'd0, 32'h20,  32'd1,   5'd3, 32'h20, 5'd1, 4'd10},       // R10
        '{4'd9,  1'b0, 1'b1, 3'd0, 32'd0,   32'd1,   5'd3, 32'h1F, 5'd1, 4'd5},        // R5
        '{4'd14, 1'b0, 1'b1, 3'd0, 32'd0,   32'h1F,  5'd4, 32'd0, 5'd0, 4'd9},         // R9
        '{4'd11, 1'b0, 1'b1, 3'd6, 32'd0,   32'h1F,  5'd4, 32'hFF, 5'd1, 4'd7},        // R7
        '{4'd10, 1'b1, 1'b1, 3'd0, 32'd0,   32'h1F,  5'd4, 32'hFFFFFF00, 5'd2, 4'd5},  // R5
        '{4'd2,  1'b0, 1'b0, 3'd0, 32'd0,   32'd1,   5'd3, 32'hFFFFFF00, 5'd2, 4'd2},  // R2
        '{4'd3,  1'b0, 1'b0, 3'd0, 32'd0,   32'd1,   5'd2, 32'hFFFFFF00, 5'd2, 4'd2},  // R2
        '{4'd13, 1'b0, 1'b0, 3'd3, 32'd0,   32'd7,   5'd1, 32'hFFFFFF00, 5'd2, 4'd8},  // R8
        '{4'd12, 1'b0, 1'b0, 3'd3, 32'd0,   32'd1,   5'd2, 32'hFFFFFF00, 5'd2, 4'd8},  // R8
        '{4'd14, 1'b1, 1'b0, 3'd0, 32'd0,   32'd1,   5'd2, 32'd1, 5'd3, 4'd9}          // R9
    };

    task automatic check(input int req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic keep, input logic stg,
                         input logic [2:0] idx, input logic [31:0] din);
        cmd_op = op; cmd_keep = keep; cmd_stg = stg; cmd_idx = idx;
        push_data = din; push_valid = 1'b1; pop_ready = 1'b1; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; push_valid = 1'b0; pop_ready = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check(1, "main depth", 32'(main_depth), 32'd0);
        check(1, "stg depth", 32'(stg_depth), 32'd0);
        check(1, "tops", main_top | stg_top, 32'd0);
        check(1, "faults", {29'd0, flt_over, flt_under, flt_illegal}, 32'd0);
        cmd_op = 4'd0; cmd_valid = 1'b1; #1;
        check(1, "cmd_ready", 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b0;

        for (int v = 0; v < NV; v++) begin
            issue(VECS[v].op, VECS[v].keep, VECS[v].stg, VECS[v].idx, VECS[v].din);
            check(VECS[v].req, $sformatf("vec %0d main top", v), main_top, VECS[v].mtop);
            check(VECS[v].req, $sformatf("vec %0d main depth", v), 32'(main_depth), 32'(VECS[v].mdep));
            check(VECS[v].req, $sformatf("vec %0d stg top", v), stg_top, VECS[v].stop);
            check(VECS[v].req, $sformatf("vec %0d stg depth", v), 32'(stg_depth), 32'(VECS[v].sdep));
        end
        // state: main [7,1], stg [FF, FFFFFF00, 1], pinned3 = 1

        // R1 untouched pinned register reads zero; R8 preserving STP
        issue(4'd12, 1'b0, 1'b0, 3'd5, 32'd0);
        check(1, "pinned5 after reset", main_top, 32'd0);
        issue(4'd13, 1'b1, 1'b0, 3'd6, 32'd0);          // R8 keep: depth stays 3
        check(8, "STP keep depth", 32'(main_depth), 32'd3);
        issue(4'd12, 1'b0, 1'b1, 3'd6, 32'd0);
        check(8, "LDP pinned6", stg_top, 32'd0);

        // R7 every constant onto staging (depth 4 -> 12)
        for (int i = 0; i < 8; i++) begin
            logic [31:0] e;
            case (i)
                0: e = 32'd0; 1: e = 32'd1; 2: e = 32'hFFFFFFFF; 3: e = 32'd2;
                4: e = 32'd4; 5: e = 32'd8; 6: e = 32'hFF; default: e = 32'hFFFFFFFF;
            endcase
            issue(4'd11, 1'b0, 1'b1, 3'(i), 32'd0);
            check(7, $sformatf("const %0d", i), stg_top, e);
        end

        // R10 store: main top is 0 (depth 3: [7,1,0])
        cmd_op = 4'd7; cmd_keep = 1'b0; cmd_stg = 1'b0; cmd_valid = 1'b1; pop_ready = 1'b0;
        #1;
        check(10, "store stalls", 32'(cmd_ready), 32'd0);
        check(10, "store pop_valid", 32'(pop_valid), 32'd1);
        @(posedge clk); @(negedge clk);
        check(10, "stalled store depth", 32'(main_depth), 32'd3);
        pop_ready = 1'b1;
        issue(4'd7, 1'b0, 1'b0, 3'd0, 32'd0);
        check(10, "store pops", 32'(main_depth), 32'd2);
        cmd_op = 4'd7; cmd_valid = 1'b1; pop_ready = 1'b1; #1;
        check(10, "store data", pop_data, 32'd1);
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0; pop_ready = 1'b0;
        check(10, "store consumed", 32'(main_depth), 32'd1);
        // load stall
        cmd_op = 4'd15; cmd_valid = 1'b1; push_valid = 1'b0; #1;
        check(10, "load stalls", 32'(cmd_ready), 32'd0);
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        check(10, "stalled load depth", 32'(main_depth), 32'd1);

        // R6 staging rejects arithmetic and store
        issue(4'd0, 1'b0, 1'b1, 3'd0, 32'd0);
        check(6, "stg ADD depth", 32'(stg_depth), 32'd12);
        check(6, "stg ADD top", stg_top, 32'hFFFFFFFF);
        check(6, "illegal flag", 32'(flt_illegal), 32'd1);
        issue(4'd7, 1'b0, 1'b1, 3'd0, 32'd0);
        check(6, "stg STORE depth", 32'(stg_depth), 32'd12);

        // R11 underflow
        do_reset();
        issue(4'd0, 1'b0, 1'b0, 3'd0, 32'd0);
        check(11, "underflow flag", 32'(flt_under), 32'd1);
        check(11, "underflow depth", 32'(main_depth), 32'd0);
        check(11, "underflow no ovf", 32'(flt_over), 32'd0);
        issue(4'd11, 1'b0, 1'b0, 3'd1, 32'd0);
        issue(4'd1, 1'b1, 1'b0, 3'd0, 32'd0);            // peek 2 with 1 present
        check(11, "peek underflow depth", 32'(main_depth), 32'd1);
        check(11, "peek underflow top", main_top, 32'd1);
        check(11, "sticky under", 32'(flt_under), 32'd1);

        // R12 overflow
        do_reset();
        for (int i = 0; i < 16; i++) issue(4'd11, 1'b0, 1'b0, 3'd5, 32'd0);
        check(12, "full depth", 32'(main_depth), 32'd16);
        check(12, "no early ovf", 32'(flt_over), 32'd0);
        issue(4'd11, 1'b0, 1'b0, 3'd1, 32'd0);
        check(12, "ovf flag", 32'(flt_over), 32'd1);
        check(12, "ovf depth", 32'(main_depth), 32'd16);
        check(12, "ovf top", main_top, 32'd8);
        issue(4'd0, 1'b0, 1'b0, 3'd0, 32'd0);            // consuming ADD still fine
        check(12, "sticky ovf", 32'(flt_over), 32'd1);
        check(2, "add at full", main_top, 32'd16);
        issue(4'd8, 1'b0, 1'b0, 3'd0, 32'd0);            // R5 consuming INC
        check(5, "inc replaces", main_top, 32'd17);
        check(5, "inc depth", 32'(main_depth), 32'd15);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule